// File: doc/BRIEF.md
# I2C SCL Low/High Divider Calculator

This block turns a functional clock rate and a requested serial-clock rate into two separate divider settings: one for the low phase of SCL and one for the high phase. One divider unit is eight functional-clock cycles. The two values are chosen so that the serial clock is never faster than requested. They also respect the minimum low time, the minimum high time and a maximum low time for the selected bus speed class (standard or fast). The maximum low time comes from the data-hold limit, because the timing engine that uses these values changes data halfway through the low phase. All arithmetic is unsigned integer. Seven quotients are needed, and all of them come from one shared restoring divider that a small state machine runs in turn.

Software or a bring-up sequencer puts both rates on the inputs and pulses `start`. Some hundreds of cycles later `done` pulses. From then on `div_low`, `div_high`, `conflict` and `error` hold their values until the next calculation completes. The divider outputs already have one subtracted from them, because the consuming timing hardware adds one to each field.

The state machine has these states: `ST_IDLE` (waits for start), `ST_CLKK` (clock kHz), `ST_SCLK` (SCL kHz), `ST_TOT` (minimum total), `ST_MINLO` (minimum low), `ST_MINHI` (minimum high), `ST_MAXLO` (maximum low), `ST_IDEAL` (ideal low) and `ST_FINISH` (outputs registered).

Its transitions are as follows:
- IDLE→CLKK happens on `start`.
- Each division state moves to the next one, in the order listed above, on the cycle the shared divider reports completion.
- IDEAL→FINISH happens on that same divider completion.
- FINISH→IDLE happens unconditionally.

Top module: `i2c_scl_divcalc`

## Requirements
- R1: The requested SCL rate is limited to the range 1000 Hz to 400000 Hz before use. A request above the range gives the same result as 400000, and a request below it gives the same result as 1000.
- R2: A limited rate of 100000 Hz or less selects standard timing: minimum low 4700 ns, minimum high 4000 ns, data hold 3450 ns. A higher rate selects fast timing: 1300 ns, 600 ns and 900 ns. The maximum low time is twice the hold time minus 50 ns, and the minimum period is the minimum low time plus the minimum high time.
- R3: The clock rate in kHz is ceil(clk_hz/1000). The SCL rate in kHz is floor(scl_hz/1000).
- R4: Minimum total = ceil(clk_khz/(8·scl_khz)). Minimum low and minimum high = ceil(clk_khz·t_ns/8000000). Maximum low = floor(clk_khz·max_low_ns/8000000).
- R5: `conflict` is 1 when the minimum low exceeds the maximum low. In that case the maximum low is raised to the minimum low.
- R6: When minimum low + minimum high > minimum total, the low and high results are the two minimums.
- R7: Otherwise, spare = total − (minimum low + minimum high). The low result is ceil(clk_khz·min_low_ns/(8·scl_khz·min_period_ns)), capped first at the maximum low and then at minimum low + spare. The high result is minimum high + spare − (low − minimum low).
- R8: `div_low` and `div_high` are the results minus one, truncated to 16 bits. `error` is 1 when either result minus one is 65535 or larger.
- R9: `start` is accepted only while idle. The rates are captured at acceptance, and a `start` during a calculation changes nothing.
- R10: `done` is high for exactly one cycle per calculation. The four result outputs change only in the cycle after `ST_FINISH` and hold otherwise.
- R11: Clock rates up to 4294967295 Hz give exact results with no intermediate overflow, because all products are at least 48 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (taken when idle) |
| clk_rate_hz | input | 32 | Functional clock rate in Hz |
| scl_rate_hz | input | 32 | Requested SCL rate in Hz |
| done | output | 1 | One-cycle completion pulse |
| div_low | output | 16 | Low-phase divider minus one |
| div_high | output | 16 | High-phase divider minus one |
| conflict | output | 1 | Minimum low exceeded maximum low |
| error | output | 1 | A divider minus one reached 65535 |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. The state machine is back in `ST_IDLE` while `done` is high, so a `start` driven in that very cycle is accepted. The bench provokes this by raising `start` with different rates in the cycle it sees `done`. It then judges two things: that the first set of results stays on the outputs throughout the second calculation, and that the second completion carries the values for the new rates. It also fires `start` in the middle of a calculation and checks that the result matches the original request.

// File: rtl/i2cdiv_pkg.sv
package i2cdiv_pkg;

    localparam int unsigned CALC_W     = 48;
    localparam int unsigned RATE_W     = 32;
    localparam int unsigned SCL_MAX_HZ = 400000;
    localparam int unsigned SCL_MIN_HZ = 1000;
    localparam int unsigned STD_TOP_HZ = 100000;
    localparam int unsigned HOLD_PAD   = 50;
    localparam int unsigned UNIT_CLKS  = 8;
    localparam int unsigned NS_PER_MS  = 1000000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLKK,
        ST_SCLK,
        ST_TOT,
        ST_MINLO,
        ST_MINHI,
        ST_MAXLO,
        ST_IDEAL,
        ST_FINISH
    } calc_state_e;

    typedef struct packed {
        logic [15:0] low_min_ns;
        logic [15:0] high_min_ns;
        logic [15:0] low_max_ns;
        logic [15:0] period_min_ns;
    } phase_limits_t;

endpackage

// File: rtl/i2cdiv_seq_divider.sv
module i2cdiv_seq_divider #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  q_q, r_q, d_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, done_q;
    logic [W:0]    r_sh, r_diff;
    logic          fits;

    assign r_sh   = {r_q, q_q[W-1]};
    assign r_diff = r_sh - {1'b0, d_q};
    assign fits   = (r_sh >= {1'b0, d_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q    <= '0;
            r_q    <= '0;
            d_q    <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                q_q   <= num;
                r_q   <= '0;
                d_q   <= den;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                r_q   <= fits ? r_diff[W-1:0] : r_sh[W-1:0];
                q_q   <= {q_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = q_q;

    assert_div_single_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    assert_div_no_relaunch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !run_q);

endmodule

// File: rtl/i2cdiv_limits.sv
module i2cdiv_limits
    import i2cdiv_pkg::*;
(
    input  logic [RATE_W-1:0] scl_hz,
    output logic [RATE_W-1:0] scl_clamped,
    output phase_limits_t     lim
);
    localparam logic [15:0] STD_LOW  = 16'd4700;
    localparam logic [15:0] STD_HIGH = 16'd4000;
    localparam logic [15:0] STD_HOLD = 16'd3450;
    localparam logic [15:0] FST_LOW  = 16'd1300;
    localparam logic [15:0] FST_HIGH = 16'd600;
    localparam logic [15:0] FST_HOLD = 16'd900;

    logic [15:0] hold_ns;
    logic        fast;

    always_comb begin
        if (scl_hz > RATE_W'(SCL_MAX_HZ))      scl_clamped = RATE_W'(SCL_MAX_HZ);
        else if (scl_hz < RATE_W'(SCL_MIN_HZ)) scl_clamped = RATE_W'(SCL_MIN_HZ);
        else                                   scl_clamped = scl_hz;

        fast = (scl_clamped > RATE_W'(STD_TOP_HZ));
        lim.low_min_ns  = fast ? FST_LOW  : STD_LOW;
        lim.high_min_ns = fast ? FST_HIGH : STD_HIGH;
        hold_ns         = fast ? FST_HOLD : STD_HOLD;
        lim.low_max_ns    = (hold_ns << 1) - 16'(HOLD_PAD);
        lim.period_min_ns = lim.low_min_ns + lim.high_min_ns;
    end

endmodule

// File: rtl/i2cdiv_split.sv
module i2cdiv_split #(
    parameter int unsigned W     = 48,
    parameter int unsigned OUT_W = 16
) (
    input  logic [W-1:0] min_lo,
    input  logic [W-1:0] min_hi,
    input  logic [W-1:0] min_tot,
    input  logic [W-1:0] max_lo,
    input  logic [W-1:0] ideal_lo,
    output logic [W-1:0] lo_m1,
    output logic [W-1:0] hi_m1,
    output logic         conflict,
    output logic         hold_wins,
    output logic         err
);
    localparam logic [W-1:0] LIMIT = W'({OUT_W{1'b1}});

    logic [W-1:0] cap_lo, need, spare, pick, lo_v, hi_v;

    always_comb begin
        conflict  = (min_lo > max_lo);
        cap_lo    = conflict ? min_lo : max_lo;
        need      = min_lo + min_hi;
        hold_wins = (need > min_tot);
        spare     = hold_wins ? '0 : (min_tot - need);
        pick      = ideal_lo;
        if (pick > cap_lo)         pick = cap_lo;
        if (pick > min_lo + spare) pick = min_lo + spare;
        if (hold_wins) begin
            lo_v = min_lo;
            hi_v = min_hi;
        end else begin
            lo_v = pick;
            hi_v = min_hi + (spare - (pick - min_lo));
        end
        lo_m1 = lo_v - 1'b1;
        hi_m1 = hi_v - 1'b1;
        err   = (lo_m1 >= LIMIT) || (hi_m1 >= LIMIT);
    end

endmodule

// File: rtl/i2c_scl_divcalc.sv
module i2c_scl_divcalc
    import i2cdiv_pkg::*;
#(
    parameter int unsigned W     = CALC_W,
    parameter int unsigned OUT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       clk_rate_hz,
    input  logic [31:0]       scl_rate_hz,
    output logic              done,
    output logic [OUT_W-1:0]  div_low,
    output logic [OUT_W-1:0]  div_high,
    output logic              conflict,
    output logic              error
);
    localparam logic [W-1:0] KILO    = W'(1000);
    localparam logic [W-1:0] UNIT_NS = W'(UNIT_CLKS * NS_PER_MS);

    calc_state_e   state_q, state_d;
    logic [31:0]   req_clk_q, req_scl_q, scl_clamped;
    phase_limits_t lim;
    logic          issued_q, div_go, div_done, in_div;
    logic [W-1:0]  num, den, quo;
    logic [W-1:0]  ck_q, sk_q, tot_q, mlo_q, mhi_q, mxlo_q, ideal_q;
    logic [W-1:0]  sk8, lo_m1, hi_m1;
    logic          conf_c, hold_wins, err_c;

    i2cdiv_limits u_limits (
        .scl_hz      (req_scl_q),
        .scl_clamped (scl_clamped),
        .lim         (lim)
    );

    i2cdiv_seq_divider #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (num),
        .den   (den),
        .done  (div_done),
        .quo   (quo)
    );

    i2cdiv_split #(.W(W), .OUT_W(OUT_W)) u_split (
        .min_lo    (mlo_q),
        .min_hi    (mhi_q),
        .min_tot   (tot_q),
        .max_lo    (mxlo_q),
        .ideal_lo  (ideal_q),
        .lo_m1     (lo_m1),
        .hi_m1     (hi_m1),
        .conflict  (conf_c),
        .hold_wins (hold_wins),
        .err       (err_c)
    );

    assign sk8    = sk_q << 3;
    assign in_div = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign div_go = in_div && !issued_q;

    // operand selection for the shared divider
    always_comb begin
        num = '0;
        den = W'(1);
        unique case (state_q)
            ST_CLKK: begin
                num = W'(req_clk_q) + KILO - 1'b1;
                den = KILO;
            end
            ST_SCLK: begin
                num = W'(scl_clamped);
                den = KILO;
            end
            ST_TOT: begin
                num = ck_q + sk8 - 1'b1;
                den = sk8;
            end
            ST_MINLO: begin
                num = ck_q * W'(lim.low_min_ns) + UNIT_NS - 1'b1;
                den = UNIT_NS;
            end
            ST_MINHI: begin
                num = ck_q * W'(lim.high_min_ns) + UNIT_NS - 1'b1;
                den = UNIT_NS;
            end
            ST_MAXLO: begin
                num = ck_q * W'(lim.low_max_ns);
                den = UNIT_NS;
            end
            ST_IDEAL: begin
                den = sk8 * W'(lim.period_min_ns);
                num = ck_q * W'(lim.low_min_ns) + den - 1'b1;
            end
            default: begin
                num = '0;
                den = W'(1);
            end
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)    state_d = ST_CLKK;
            ST_CLKK:   if (div_done) state_d = ST_SCLK;
            ST_SCLK:   if (div_done) state_d = ST_TOT;
            ST_TOT:    if (div_done) state_d = ST_MINLO;
            ST_MINLO:  if (div_done) state_d = ST_MINHI;
            ST_MINHI:  if (div_done) state_d = ST_MAXLO;
            ST_MAXLO:  if (div_done) state_d = ST_IDEAL;
            ST_IDEAL:  if (div_done) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_clk_q <= '0;
            req_scl_q <= '0;
            issued_q  <= 1'b0;
            ck_q      <= '0;
            sk_q      <= '0;
            tot_q     <= '0;
            mlo_q     <= '0;
            mhi_q     <= '0;
            mxlo_q    <= '0;
            ideal_q   <= '0;
            done      <= 1'b0;
            div_low   <= '0;
            div_high  <= '0;
            conflict  <= 1'b0;
            error     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                req_clk_q <= clk_rate_hz;
                req_scl_q <= scl_rate_hz;
            end
            if (div_go)        issued_q <= 1'b1;
            else if (div_done) issued_q <= 1'b0;
            if (div_done) begin
                unique case (state_q)
                    ST_CLKK:  ck_q    <= quo;
                    ST_SCLK:  sk_q    <= quo;
                    ST_TOT:   tot_q   <= quo;
                    ST_MINLO: mlo_q   <= quo;
                    ST_MINHI: mhi_q   <= quo;
                    ST_MAXLO: mxlo_q  <= quo;
                    ST_IDEAL: ideal_q <= quo;
                    default:  ;
                endcase
            end
            if (state_q == ST_FINISH) begin
                done     <= 1'b1;
                div_low  <= lo_m1[OUT_W-1:0];
                div_high <= hi_m1[OUT_W-1:0];
                conflict <= conf_c;
                error    <= err_c;
            end
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FINISH) |=> ($stable(div_low) && $stable(div_high)
                                    && $stable(conflict) && $stable(error)));
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q != ST_IDLE) |=> ($stable(req_clk_q) && $stable(req_scl_q)));
    assert_clamp_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (scl_clamped >= 32'(SCL_MIN_HZ) && scl_clamped <= 32'(SCL_MAX_HZ)));
    assert_split_fills_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && !hold_wins) |-> (lo_m1 + hi_m1 + W'(2) == tot_q));
    assert_low_not_below_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |-> (lo_m1 + 1'b1 >= mlo_q));

endmodule

// File: tb/i2c_scl_divcalc_tb.sv
module i2c_scl_divcalc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] clk_rate_hz = '0;
    logic [31:0] scl_rate_hz = '0;
    logic        done, conflict, error;
    logic [15:0] div_low, div_high;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    i2c_scl_divcalc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .clk_rate_hz (clk_rate_hz),
        .scl_rate_hz (scl_rate_hz),
        .done        (done),
        .div_low     (div_low),
        .div_high    (div_high),
        .conflict    (conflict),
        .error       (error)
    );

    // expected {conflict, error, low, high} from the requirements
    function automatic logic [33:0] model(input logic [31:0] ch, input logic [31:0] sh);
        longint unsigned s, lo_ns, hi_ns, hold, mx_ns, per_ns;
        longint unsigned ck, sk, mt, ml, mh, mx, lo, hi, ex, id, d;
        logic cf, er;
        s = sh;
        if (s > 400000) s = 400000;
        if (s < 1000)   s = 1000;
        if (s <= 100000) begin lo_ns = 4700; hi_ns = 4000; hold = 3450; end
        else             begin lo_ns = 1300; hi_ns = 600;  hold = 900;  end
        mx_ns  = 2 * hold - 50;
        per_ns = lo_ns + hi_ns;
        ck = (longint'(ch) + 999) / 1000;
        sk = s / 1000;
        mt = (ck + sk * 8 - 1) / (sk * 8);
        ml = (ck * lo_ns + 7999999) / 8000000;
        mh = (ck * hi_ns + 7999999) / 8000000;
        mx = (ck * mx_ns) / 8000000;
        cf = (ml > mx);
        if (cf) mx = ml;
        if (ml + mh > mt) begin
            lo = ml; hi = mh;
        end else begin
            ex = mt - ml - mh;
            d  = sk * 8 * per_ns;
            id = (ck * lo_ns + d - 1) / d;
            if (id > mx) id = mx;
            if (id > ml + ex) id = ml + ex;
            lo = id;
            hi = mh + ex - (id - ml);
        end
        lo = lo - 1;
        hi = hi - 1;
        er = (lo >= 65535) || (hi >= 65535);
        return {cf, er, lo[15:0], hi[15:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    task automatic check_outputs(input string req, input logic [33:0] e);
        chk({req, " div_low"},  32'(div_low),  32'(e[31:16]));
        chk({req, " div_high"}, 32'(div_high), 32'(e[15:0]));
        chk({req, " conflict"}, 32'(conflict), 32'(e[33]));
        chk({req, " error"},    32'(error),    32'(e[32]));
    endtask

    // launch, wait, compare, then confirm single-cycle done and held outputs
    task automatic run_case(input string req, input logic [31:0] ch, input logic [31:0] sh);
        bit ok;
        logic [33:0] e;
        e = model(ch, sh);
        @(negedge clk);
        clk_rate_hz = ch; scl_rate_hz = sh; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk({req, " done seen"}, 32'(ok), 32'd1);
        check_outputs(req, e);
        @(negedge clk);
        chk("R10 done one cycle", 32'(done), 32'd0);
        repeat (3) @(negedge clk);
        chk("R10 low held", 32'(div_low), 32'(e[31:16]));
    endtask

    task automatic test_reset;
        chk("reset done",     32'(done),     32'd0);
        chk("reset div_low",  32'(div_low),  32'd0);
        chk("reset div_high", 32'(div_high), 32'd0);
        chk("reset conflict", 32'(conflict), 32'd0);
        chk("reset error",    32'(error),    32'd0);
    endtask

    task automatic test_clamp;
        logic [33:0] a, b;
        run_case("R1 above range", 32'd100_000_000, 32'd1_000_000);
        a = model(32'd100_000_000, 32'd1_000_000);
        b = model(32'd100_000_000, 32'd400_000);
        chk("R1 high clamp equals 400k", 32'(a[31:0]), 32'(b[31:0]));
        run_case("R1 below range", 32'd50_000_000, 32'd10);
    endtask

    task automatic test_busy_ignore;
        bit ok;
        logic [33:0] e;
        e = model(32'd200_000_000, 32'd100_000);
        @(negedge clk);
        clk_rate_hz = 32'd200_000_000; scl_rate_hz = 32'd100_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        clk_rate_hz = 32'd12_000_000; scl_rate_hz = 32'd400_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk("R9 done", 32'(ok), 32'd1);
        check_outputs("R9 mid-run start ignored", e);
        repeat (5) @(negedge clk);
        chk("R9 no extra done", 32'(done), 32'd0);
    endtask

    task automatic test_back_to_back;
        bit ok;
        logic [33:0] e1, e2;
        e1 = model(32'd48_000_000, 32'd400_000);
        e2 = model(32'd24_000_000, 32'd100_000);
        @(negedge clk);
        clk_rate_hz = 32'd48_000_000; scl_rate_hz = 32'd400_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        check_outputs("R10 first of pair", e1);
        clk_rate_hz = 32'd24_000_000; scl_rate_hz = 32'd100_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        check_outputs("R10 held during second run", e1);
        wait_done(ok);
        chk("R9 start with done accepted", 32'(ok), 32'd1);
        check_outputs("R9 second of pair", e2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_case("R7 100MHz 100k", 32'd100_000_000, 32'd100_000);
        chk("R7 100MHz 100k low value",  32'(div_low),  32'd67);
        chk("R7 100MHz 100k high value", 32'(div_high), 32'd56);
        run_case("R7 100MHz 400k", 32'd100_000_000, 32'd400_000);
        run_case("R2 boundary 100000", 32'd66_000_000, 32'd100_000);
        run_case("R2 boundary 100001", 32'd66_000_000, 32'd100_001);
        run_case("R3 clock kHz rounds up", 32'd100_000_001, 32'd250_000);
        run_case("R3 scl kHz rounds down", 32'd33_000_000, 32'd399_999);
        run_case("R4 R6 minimums win", 32'd10_000_000, 32'd400_000);
        run_case("R5 conflict", 32'd1_000_000, 32'd400_000);
        chk("R5 conflict set", 32'(conflict), 32'd1);
        run_case("R8 R11 large clock", 32'd4_000_000_000, 32'd1_000);
        chk("R8 error set", 32'(error), 32'd1);
        chk("R8 low value", 32'(div_low), 32'd3424);
        run_case("R11 max clock", 32'hFFFF_FFFF, 32'd400_000);
        test_clamp();
        test_busy_ignore();
        test_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule